// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Block

This block collects the event and level signals of an SD host controller into two 16-bit status registers, each paired with its own 16-bit interrupt mask register. The command engine, the data engine and the card-detect logic feed it with one-cycle event pulses and with live levels. The block raises a single interrupt line whenever an unmasked event bit is set.

Software reaches the four registers through a small port. It has a 2-bit address, write data, a write enable and combinational read data. The address codes are 0 for the first status register, 1 for the second status register, 2 for the first mask and 3 for the second mask. Event bits are sticky. Software clears an event bit by writing 0 to that bit, and a 1 in the same write leaves the bit as it is. The level bits show the current value of their input and ignore writes. The two buffer-ready bits are set by the rising edge of a buffer level, not by the level itself. Software can therefore clear a buffer-ready bit before it moves the block of data, and the event for the next block is still caught.

Top module: `sdh_irq_status`

## Requirements
- R1: After a synchronous active-low reset, every event bit is 0, both mask registers read 0xFFFF and `irq` is 0.
- R2: A one-cycle pulse sets its bit in the first status register (address 0) at the next clock edge, and the bit stays set. The bits are card inserted at bit 4, card removed at bit 3, data done at bit 2 and response done at bit 0.
- R3: A one-cycle pulse sets its bit in the second status register (address 1) at the next clock edge, and the bit stays set. `ev_err[k]` sets bit k for k = 0..6, and the illegal-access pulse sets bit 15.
- R4: A write to a status register clears each event bit written as 0 and leaves each event bit written as 1 unchanged.
- R5: When an event arrives in the same cycle as a write that clears its bit, the bit is 1 after that edge.
- R6: Three bits show their input levels in the same cycle and ignore writes: card present at address 0 bit 5, command busy at address 1 bit 14, and the DAT0 line at address 1 bit 7.
- R7: Read-buffer-ready (address 1 bit 8) is set only when `lvl_rd_full` rises from 0 to 1. After it is cleared it stays 0 while the level stays high, and it is set again on the next rise.
- R8: Write-buffer-ready (address 1 bit 9) is set only when `lvl_wr_empty` rises from 0 to 1, with the same clear behaviour as R7.
- R9: Mask registers at addresses 2 and 3 store all 16 written bits and read them back.
- R10: `irq` is 1 exactly when some event bit is 1 and its mask bit is 0. Level bits never raise `irq`.
- R11: Status bit positions that are neither event bits nor level bits always read 0, even after writes of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_card_in | input | 1 | Pulse: card inserted |
| ev_card_out | input | 1 | Pulse: card removed |
| ev_data_done | input | 1 | Pulse: data transfer complete |
| ev_resp_done | input | 1 | Pulse: response received |
| ev_err | input | 7 | Pulses: error events for status-2 bits 6..0 |
| ev_illegal | input | 1 | Pulse: illegal register access |
| lvl_card | input | 1 | Live card-present level |
| lvl_cmd_busy | input | 1 | Live command-busy level |
| lvl_dat0 | input | 1 | Live DAT0 line level |
| lvl_rd_full | input | 1 | Level: read buffer holds a full block |
| lvl_wr_empty | input | 1 | Level: write buffer can take a block |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write enable |
| reg_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The key collision is a software clear of an event bit in the same cycle as a hardware event for that bit. The event must win (R5). The bench provokes this by pulsing an event input together with an all-zero write to its status register. It also provokes it for the edge-set buffer-ready bits by raising a buffer level in the same cycle as the clear. A behavioural reference model follows every cycle, and the bench compares read data and `irq` against it on every falling edge. A randomized stretch of mixed writes, pulses and level changes then produces many more such collisions.

// File: rtl/sdh_irq_pkg.sv
// Shared constants for the SD host interrupt status block.
// Assumes a 16-bit register port and four register addresses.
package sdh_irq_pkg;
    localparam int DW    = 16;
    localparam int AW    = 2;
    localparam int ERR_W = 7;
    localparam int NBUF  = 2;

    // status 1 bit positions
    localparam int S1_CARD = 5;
    localparam int S1_INS  = 4;
    localparam int S1_REM  = 3;
    localparam int S1_DONE = 2;
    localparam int S1_RESP = 0;

    // status 2 bit positions
    localparam int S2_ILLG = 15;
    localparam int S2_BUSY = 14;
    localparam int S2_WRDY = 9;
    localparam int S2_RRDY = 8;
    localparam int S2_DAT0 = 7;

    // bits holding sticky events
    localparam logic [DW-1:0] S1_EVT = 16'h001D;
    localparam logic [DW-1:0] S2_EVT = 16'h837F;

    typedef enum logic [AW-1:0] {
        SEL_STAT1 = 2'd0,
        SEL_STAT2 = 2'd1,
        SEL_MASK1 = 2'd2,
        SEL_MASK2 = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/sdh_edge_det.sv
// Rising-edge detector for W independent levels.
// Assumes levels are synchronous to clk; the previous value is 0 after reset.
module sdh_edge_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        // remember last level of bit g
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= lvl[g];
        end
        assign rise[g] = lvl[g] & ~prev_q[g];
    end
endmodule

// File: rtl/sdh_evt_reg.sv
// Sticky event register: set by event pulses, cleared by writing 0.
// Only bits in EVT_MASK hold state; a set in the same cycle as a clear wins.
module sdh_evt_reg #(
    parameter int            W        = 16,
    parameter logic [W-1:0]  EVT_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_sel,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);
    logic [W-1:0] keep;

    // bits kept across this cycle: write-0 clears, write-1 keeps
    always_comb begin
        keep = wr_sel ? wdata : {W{1'b1}};
    end

    // update sticky state, event pulses dominate clears
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= ((q & keep) | set) & EVT_MASK;
    end
endmodule

// File: rtl/sdh_mask_reg.sv
// Plain read/write mask register; all ones after reset (everything masked).
module sdh_mask_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // load on write, reset to fully masked
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '1;
        else if (wr_sel) q <= wdata;
    end
endmodule

// File: rtl/sdh_irq_status.sv
// SD host interrupt status top: two status registers, two masks, one irq.
// Assumes event inputs are one-cycle pulses and levels are synchronous.
module sdh_irq_status
    import sdh_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_card_in,
    input  logic             ev_card_out,
    input  logic             ev_data_done,
    input  logic             ev_resp_done,
    input  logic [ERR_W-1:0] ev_err,
    input  logic             ev_illegal,
    input  logic             lvl_card,
    input  logic             lvl_cmd_busy,
    input  logic             lvl_dat0,
    input  logic             lvl_rd_full,
    input  logic             lvl_wr_empty,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic             reg_we,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq
);
    logic [DW-1:0]   s1_q, s2_q, m1_q, m2_q;
    logic [DW-1:0]   s1_set, s2_set;
    logic [NBUF-1:0] buf_lvl, buf_rise;
    logic            wr_s1, wr_s2, wr_m1, wr_m2;
    reg_sel_e        sel;

    // decode the register select for writes
    always_comb begin
        sel   = reg_sel_e'(reg_addr);
        wr_s1 = reg_we && (sel == SEL_STAT1);
        wr_s2 = reg_we && (sel == SEL_STAT2);
        wr_m1 = reg_we && (sel == SEL_MASK1);
        wr_m2 = reg_we && (sel == SEL_MASK2);
    end

    assign buf_lvl = {lvl_wr_empty, lvl_rd_full};

    sdh_edge_det #(.W(NBUF)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (buf_lvl),
        .rise (buf_rise)
    );

    // gather event pulses into their status bit positions
    always_comb begin
        s1_set          = '0;
        s1_set[S1_INS]  = ev_card_in;
        s1_set[S1_REM]  = ev_card_out;
        s1_set[S1_DONE] = ev_data_done;
        s1_set[S1_RESP] = ev_resp_done;
        s2_set              = '0;
        s2_set[ERR_W-1:0]   = ev_err;
        s2_set[S2_ILLG]     = ev_illegal;
        s2_set[S2_RRDY]     = buf_rise[0];
        s2_set[S2_WRDY]     = buf_rise[1];
    end

    sdh_evt_reg #(.W(DW), .EVT_MASK(S1_EVT)) u_stat1 (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_s1),
        .wdata(reg_wdata), .set(s1_set), .q(s1_q)
    );

    sdh_evt_reg #(.W(DW), .EVT_MASK(S2_EVT)) u_stat2 (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_s2),
        .wdata(reg_wdata), .set(s2_set), .q(s2_q)
    );

    sdh_mask_reg #(.W(DW)) u_mask1 (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_m1),
        .wdata(reg_wdata), .q(m1_q)
    );

    sdh_mask_reg #(.W(DW)) u_mask2 (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_m2),
        .wdata(reg_wdata), .q(m2_q)
    );

    // read mux, overlaying live levels onto the status words
    always_comb begin
        unique case (sel)
            SEL_STAT1: begin
                reg_rdata          = s1_q;
                reg_rdata[S1_CARD] = lvl_card;
            end
            SEL_STAT2: begin
                reg_rdata          = s2_q;
                reg_rdata[S2_BUSY] = lvl_cmd_busy;
                reg_rdata[S2_DAT0] = lvl_dat0;
            end
            SEL_MASK1: reg_rdata = m1_q;
            default:   reg_rdata = m2_q;
        endcase
    end

    // interrupt from unmasked event bits only
    assign irq = |(s1_q & ~m1_q & S1_EVT) | |(s2_q & ~m2_q & S2_EVT);
endmodule

// File: rtl/sdh_irq_chk.sv
// Assertion checker for sdh_irq_status, attached by bind.
module sdh_irq_chk
    import sdh_irq_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic          ev_card_in,
    input logic          lvl_rd_full,
    input logic [DW-1:0] s1_q,
    input logic [DW-1:0] s2_q,
    input logic [DW-1:0] m1_q,
    input logic [DW-1:0] m2_q,
    input logic          irq
);
    // R2: an inserted-card bit stays set unless status 1 was written
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(s1_q[S1_INS]) &&
         !($past(reg_we) && $past(reg_addr) == 2'd0)) |-> s1_q[S1_INS]);

    // R5: an event pulse always leaves its bit set, even under a clear
    a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ev_card_in)) |-> s1_q[S1_INS]);

    // R7: read-buffer-ready only rises while the buffer level is high
    a_r7_edge_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s2_q[S2_RRDY]) |-> $past(lvl_rd_full));

    // R10: with everything masked, no interrupt
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (m1_q == '1 && m2_q == '1) |-> !irq);

    // R11: unused status bits never hold state
    a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((s1_q & ~S1_EVT) == '0) && ((s2_q & ~S2_EVT) == '0));
endmodule

bind sdh_irq_status sdh_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .ev_card_in (ev_card_in),
    .lvl_rd_full(lvl_rd_full),
    .s1_q       (s1_q),
    .s2_q       (s2_q),
    .m1_q       (m1_q),
    .m2_q       (m2_q),
    .irq        (irq)
);

// File: tb/sim_sdh_irq_status.sv
// Bench: behavioural reference model compared on every falling edge.
module sim_sdh_irq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_card_in = 0, ev_card_out = 0, ev_data_done = 0, ev_resp_done = 0;
    logic [6:0]  ev_err = '0;
    logic        ev_illegal = 0;
    logic        lvl_card = 0, lvl_cmd_busy = 0, lvl_dat0 = 0;
    logic        lvl_rd_full = 0, lvl_wr_empty = 0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 0;
    logic [15:0] reg_rdata;
    logic        irq;

    int    n_tests = 0, n_fail = 0, cycles = 0;
    string phase = "R1";
    bit    live = 0;

    // reference state
    int unsigned r_s1 = 0, r_s2 = 0, r_k1 = 16'hFFFF, r_k2 = 16'hFFFF;
    bit          r_prb = 0, r_pwb = 0;

    always #2 clk = ~clk;

    sdh_irq_status u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_card_in(ev_card_in), .ev_card_out(ev_card_out),
        .ev_data_done(ev_data_done), .ev_resp_done(ev_resp_done),
        .ev_err(ev_err), .ev_illegal(ev_illegal),
        .lvl_card(lvl_card), .lvl_cmd_busy(lvl_cmd_busy), .lvl_dat0(lvl_dat0),
        .lvl_rd_full(lvl_rd_full), .lvl_wr_empty(lvl_wr_empty),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // model update at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            r_s1 = 0; r_s2 = 0; r_k1 = 16'hFFFF; r_k2 = 16'hFFFF;
            r_prb = 0; r_pwb = 0;
        end else begin
            if (reg_we) begin
                if (reg_addr == 0) r_s1 = r_s1 & reg_wdata;
                if (reg_addr == 1) r_s2 = r_s2 & reg_wdata;
                if (reg_addr == 2) r_k1 = reg_wdata;
                if (reg_addr == 3) r_k2 = reg_wdata;
            end
            if (ev_card_in)   r_s1 = r_s1 | 16'h0010;
            if (ev_card_out)  r_s1 = r_s1 | 16'h0008;
            if (ev_data_done) r_s1 = r_s1 | 16'h0004;
            if (ev_resp_done) r_s1 = r_s1 | 16'h0001;
            r_s2 = r_s2 | ev_err;
            if (ev_illegal) r_s2 = r_s2 | 16'h8000;
            if (lvl_rd_full && !r_prb)  r_s2 = r_s2 | 16'h0100;
            if (lvl_wr_empty && !r_pwb) r_s2 = r_s2 | 16'h0200;
            r_prb = lvl_rd_full;
            r_pwb = lvl_wr_empty;
            r_s1 = r_s1 & 16'h001D;
            r_s2 = r_s2 & 16'h837F;
        end
    end

    // compare outputs at the falling edge, before new stimulus
    always @(negedge clk) begin
        int unsigned exp_rd;
        bit exp_irq;
        if (live) begin
            case (reg_addr)
                2'd0: exp_rd = r_s1 | (32'(lvl_card) << 5);
                2'd1: exp_rd = r_s2 | (32'(lvl_cmd_busy) << 14) | (32'(lvl_dat0) << 7);
                2'd2: exp_rd = r_k1;
                default: exp_rd = r_k2;
            endcase
            exp_irq = ((r_s1 & ~r_k1 & 16'h001D) != 0) || ((r_s2 & ~r_k2 & 16'h837F) != 0);
            n_tests++;
            if (reg_rdata !== exp_rd[15:0] || irq !== exp_irq) begin
                n_fail++;
                $display("FAIL %s addr=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                         phase, reg_addr, reg_rdata, irq, exp_rd[15:0], exp_irq);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // advance one cycle; pulses and writes last one cycle
    task automatic tick();
        @(negedge clk);
        #1;
        ev_card_in = 0; ev_card_out = 0; ev_data_done = 0; ev_resp_done = 0;
        ev_err = '0; ev_illegal = 0; reg_we = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1; tick();
    endtask

    task automatic rd(input logic [1:0] a);
        reg_addr = a; tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1; live = 1;
        // R1: reset state on all four addresses
        phase = "R1";
        for (int a = 0; a < 4; a++) rd(2'(a));
        // R9: mask read-back
        phase = "R9";
        wr(2, 16'hA5C3); rd(2); wr(3, 16'h3C5A); rd(3);
        wr(2, 16'hFFFF); wr(3, 16'hFFFF); rd(2);
        // R2: status 1 events
        phase = "R2";
        reg_addr = 0;
        ev_card_in = 1; tick(); rd(0);
        ev_card_out = 1; tick(); ev_data_done = 1; tick();
        ev_resp_done = 1; tick(); rd(0); rd(0);
        // R3: status 2 error events
        phase = "R3";
        for (int k = 0; k < 7; k++) begin
            reg_addr = 1; ev_err = 7'(1 << k); tick();
        end
        ev_illegal = 1; tick(); rd(1);
        // R4: selective clears
        phase = "R4";
        wr(0, 16'hFFEF); rd(0); wr(1, 16'h7FFE); rd(1);
        wr(0, 16'h0000); rd(0);
        // R5: event with clear in the same cycle
        phase = "R5";
        reg_addr = 0; reg_wdata = 0; reg_we = 1; ev_data_done = 1; tick(); rd(0);
        reg_addr = 1; reg_wdata = 0; reg_we = 1; ev_err = 7'h04; tick(); rd(1);
        // R6: level mirrors ignore writes
        phase = "R6";
        lvl_card = 1; lvl_cmd_busy = 1; lvl_dat0 = 1; rd(0); rd(1);
        wr(0, 16'h0000); wr(1, 16'h0000); rd(0); rd(1);
        lvl_card = 0; lvl_cmd_busy = 0; lvl_dat0 = 0; wr(1, 16'hFFFF); rd(1); rd(0);
        // R7: read-buffer-ready on rising edge only
        phase = "R7";
        wr(1, 16'h0000);
        lvl_rd_full = 1; rd(1); rd(1);
        wr(1, 16'hFEFF); rd(1); rd(1); rd(1);
        lvl_rd_full = 0; rd(1); lvl_rd_full = 1; rd(1);
        reg_we = 1; reg_wdata = 0; lvl_rd_full = 0; tick();
        lvl_rd_full = 1; reg_we = 1; reg_wdata = 0; tick(); rd(1);
        lvl_rd_full = 0;
        // R8: write-buffer-ready on rising edge only
        phase = "R8";
        wr(1, 16'h0000);
        lvl_wr_empty = 1; rd(1); wr(1, 16'hFDFF); rd(1); rd(1);
        lvl_wr_empty = 0; rd(1); lvl_wr_empty = 1; rd(1); lvl_wr_empty = 0;
        // R10: interrupt follows unmasked events
        phase = "R10";
        wr(1, 16'h0000); wr(0, 16'h0000);
        wr(2, 16'hFFFB); rd(0);
        ev_data_done = 1; tick(); rd(0);
        wr(2, 16'hFFFF); rd(2); wr(2, 16'h0000); rd(2);
        wr(0, 16'h0000); lvl_card = 1; lvl_dat0 = 1; lvl_cmd_busy = 1; rd(0);
        wr(3, 16'h0000); rd(1);
        ev_err = 7'h40; tick(); rd(1);
        lvl_card = 0; lvl_dat0 = 0; lvl_cmd_busy = 0;
        // R11: unused bits stay zero
        phase = "R11";
        wr(0, 16'hFFFF); rd(0); wr(1, 16'hFFFF); rd(1);
        // R5 / R10: randomized mix of clears, events and levels
        phase = "R5";
        for (int i = 0; i < 3000; i++) begin
            int unsigned r = $urandom;
            ev_card_in   = (r[2:0] == 0);
            ev_card_out  = (r[5:3] == 0);
            ev_data_done = (r[8:6] == 0);
            ev_resp_done = (r[11:9] == 0);
            ev_illegal   = (r[14:12] == 0);
            ev_err       = (r[17:15] == 0) ? 7'($urandom) : 7'h0;
            if (r[20:18] == 0) lvl_rd_full  = ~lvl_rd_full;
            if (r[23:21] == 0) lvl_wr_empty = ~lvl_wr_empty;
            lvl_card = r[24]; lvl_dat0 = r[25]; lvl_cmd_busy = r[26];
            reg_addr = r[28:27];
            reg_we   = (r[30:29] == 0);
            reg_wdata = 16'($urandom);
            tick();
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule